// File: doc/BRIEF.md
# Three-Stage DAC Calibration Pipeline

This block turns a raw DAC input code into a corrected output code for one of several channels. Each time a channel's input code is written, or a control update asks for recalculation, the block starts a job. The job takes the input code, a gain word and an offset word, and runs through three fixed-length stages in strict order. Stage one forms the gain product. Stage two scales the product and adds the offset. Stage three clamps the result and writes it into that channel's slot in an output bank.

Stage lengths are parameters, counted in clock cycles. The defaults of 130, 130 and 70 cycles give roughly 650 ns, 650 ns and 350 ns at 200 MHz. Jobs overlap, so a new job can enter stage one as soon as the previous job leaves it. A request that arrives while stage one is still occupied is dropped and reported with a one-cycle overrun pulse. Every stage carries its job's channel index, so results always land in the right slot.

Top module: `dacCalPipeline`

## Requirements
- R1: A start request (`wrDone` or `ctrlUpd` high at a rising edge) that is accepted produces `x2Valid` exactly S1+S2+S3 cycles after the accepting edge, where S1, S2 and S3 are the stage lengths.
- R2: The result is floor(X1·(M+1)/65536) + C − 32768, clamped to the range 0..65535.
- R3: On completion, `x2Chan` gives the job's channel and `x2Data` gives the result. Bank slot `x2Flat[ch*16 +: 16]` for that channel takes the result, and every other slot keeps its value.
- R4: `x2Valid` is high for exactly one cycle per completed job.
- R5: `stage1Busy` is high while stage one holds a job that will not leave at the next edge. It goes low in the last cycle of stage one.
- R6: A request accepted exactly S1 cycles after the previous accepted request is taken without overrun. Both results appear in order, S1 cycles apart.
- R7: A request made while `stage1Busy` is high is dropped. `overrun` is high for one cycle after that edge, no result is produced for the dropped request, its channel slot is unchanged, and the job already in flight completes correctly.
- R8: `ctrlUpd` starts the same calculation as `wrDone`, with the same latency.
- R9: While reset is held, `stage1Busy`, `overrun` and `x2Valid` are low and every bank slot is zero.
- R10: A job enters stage two only from stage one, and enters stage three only from stage two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrDone | input | 1 | Input-code write completed; start request |
| ctrlUpd | input | 1 | Control update requiring recalculation; start request |
| wrChan | input | 2 | Channel index of the request |
| wrX1 | input | 16 | Input code |
| wrGain | input | 16 | Gain word M |
| wrOffset | input | 16 | Offset word C |
| stage1Busy | output | 1 | Stage one cannot take a request this cycle |
| overrun | output | 1 | One-cycle pulse: a request was dropped |
| x2Valid | output | 1 | One-cycle pulse: a result is complete |
| x2Chan | output | 2 | Channel index of the completed result |
| x2Data | output | 16 | Completed calibrated code |
| x2Flat | output | 64 | Bank of calibrated codes, one 16-bit slot per channel |

## Verification
The hardest case to reach is the exact edge where stage one hands its job to stage two at the same moment a new request arrives. One cycle earlier, the request must be dropped. On that edge, it must be taken. The stimulus watches `stage1Busy` until it falls, then issues the second request at that edge, and checks that both results arrive S1 cycles apart with no overrun. A second scenario issues a request a few cycles into an occupied stage one. It then confirms that only the first job completes and that the dropped job's slot keeps its earlier value.

// File: rtl/dacCalPkg.sv
package dacCalPkg;

  // Strobes from the stage sequencer to the datapath registers
  typedef struct packed {
    logic load1;   // capture a new request into stage one
    logic adv12;   // move stage one contents into stage two
    logic adv23;   // move stage two contents into stage three
    logic wb;      // clamp stage three and write the bank
  } calStrobes_t;

endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import dacCalPkg::*;
#(
  parameter int S1_CYC = 130,
  parameter int S2_CYC = 130,
  parameter int S3_CYC = 70
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  output calStrobes_t strb,
  output logic        stage1Busy,
  output logic        overrun
);

  localparam int MAX12 = (S1_CYC > S2_CYC) ? S1_CYC : S2_CYC;
  localparam int MAXC  = (MAX12 > S3_CYC) ? MAX12 : S3_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LAST1 = CNT_W'(S1_CYC - 1);
  localparam logic [CNT_W-1:0] LAST2 = CNT_W'(S2_CYC - 1);
  localparam logic [CNT_W-1:0] LAST3 = CNT_W'(S3_CYC - 1);

  logic             s1V, s2V, s3V;
  logic [CNT_W-1:0] c1, c2, c3;
  logic             end1, end2, end3;
  logic             adv12, adv23, wbNow, accept;

  assign end1  = s1V && (c1 == LAST1);
  assign end2  = s2V && (c2 == LAST2);
  assign end3  = s3V && (c3 == LAST3);
  assign wbNow = end3;
  assign adv23 = end2 && (!s3V || wbNow);
  assign adv12 = end1 && (!s2V || adv23);
  assign accept = startReq && (!s1V || adv12);

  assign stage1Busy = s1V && !adv12;

  always_comb begin
    strb.load1 = accept;
    strb.adv12 = adv12;
    strb.adv23 = adv23;
    strb.wb    = wbNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1V     <= 1'b0;
      s2V     <= 1'b0;
      s3V     <= 1'b0;
      c1      <= '0;
      c2      <= '0;
      c3      <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= startReq && !accept;

      if (accept)      s1V <= 1'b1;
      else if (adv12)  s1V <= 1'b0;
      if (accept)             c1 <= '0;
      else if (s1V && !end1)  c1 <= c1 + 1'b1;

      if (adv12)       s2V <= 1'b1;
      else if (adv23)  s2V <= 1'b0;
      if (adv12)              c2 <= '0;
      else if (s2V && !end2)  c2 <= c2 + 1'b1;

      if (adv23)       s3V <= 1'b1;
      else if (wbNow)  s3V <= 1'b0;
      if (adv23)              c3 <= '0;
      else if (s3V && !end3)  c3 <= c3 + 1'b1;
    end
  end

  // R10
  stage2_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(s2V) |-> $past(s1V));
  // R10
  stage3_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(s3V) |-> $past(s2V));
  // R7
  overrun_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(stage1Busy));
  // R5
  stage1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (s1V && !end1) |=> s1V);

endmodule

// File: rtl/calDatapath.sv
module calDatapath
  import dacCalPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  calStrobes_t              strb,
  input  logic [$clog2(NUM_CH)-1:0] inChan,
  input  logic [DATA_W-1:0]        inX1,
  input  logic [DATA_W-1:0]        inGain,
  input  logic [DATA_W-1:0]        inOffset,
  output logic                     x2Valid,
  output logic [$clog2(NUM_CH)-1:0] x2Chan,
  output logic [DATA_W-1:0]        x2Data,
  output logic [NUM_CH*DATA_W-1:0] x2Flat
);

  localparam int CH_W   = $clog2(NUM_CH);
  localparam int PROD_W = 2 * DATA_W + 1;
  localparam int SUM_W  = DATA_W + 3;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (DATA_W - 1);
  localparam logic signed [SUM_W-1:0] TOP  = (SUM_W'(1) <<< DATA_W) - 1;

  // stage one: captured operands
  logic [DATA_W-1:0] s1X1, s1Gain, s1Off;
  logic [CH_W-1:0]   s1Chan;
  // stage two: gain product
  logic [PROD_W-1:0] s2Prod;
  logic [DATA_W-1:0] s2Off;
  logic [CH_W-1:0]   s2Chan;
  // stage three: scaled sum
  logic signed [SUM_W-1:0] s3Sum;
  logic [CH_W-1:0]         s3Chan;

  logic [PROD_W-1:0]       prodNext;
  logic signed [SUM_W-1:0] sumNext;
  logic [DATA_W-1:0]       clampVal;
  logic [DATA_W-1:0]       bank [NUM_CH];

  assign prodNext = PROD_W'(s1X1) * (PROD_W'(s1Gain) + PROD_W'(1));
  assign sumNext  = $signed(SUM_W'(s2Prod[PROD_W-1:DATA_W]))
                  + $signed(SUM_W'(s2Off)) - HALF;

  always_comb begin
    if (s3Sum < 0)          clampVal = '0;
    else if (s3Sum > TOP)   clampVal = '1;
    else                    clampVal = s3Sum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1X1 <= '0; s1Gain <= '0; s1Off <= '0; s1Chan <= '0;
      s2Prod <= '0; s2Off <= '0; s2Chan <= '0;
      s3Sum <= '0; s3Chan <= '0;
      x2Valid <= 1'b0; x2Chan <= '0; x2Data <= '0;
    end else begin
      if (strb.load1) begin
        s1X1   <= inX1;
        s1Gain <= inGain;
        s1Off  <= inOffset;
        s1Chan <= inChan;
      end
      if (strb.adv12) begin
        s2Prod <= prodNext;
        s2Off  <= s1Off;
        s2Chan <= s1Chan;
      end
      if (strb.adv23) begin
        s3Sum  <= sumNext;
        s3Chan <= s2Chan;
      end
      x2Valid <= strb.wb;
      if (strb.wb) begin
        x2Chan <= s3Chan;
        x2Data <= clampVal;
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rstN)                                  bank[g] <= '0;
      else if (strb.wb && s3Chan == CH_W'(g))     bank[g] <= clampVal;
    end
    assign x2Flat[g*DATA_W +: DATA_W] = bank[g];
  end

  // R4
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    x2Valid |=> !x2Valid);
  // R3
  result_matches_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    x2Valid |-> (x2Data == bank[x2Chan]));

endmodule

// File: rtl/dacCalPipeline.sv
module dacCalPipeline
  import dacCalPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int S1_CYC = 130,
  parameter int S2_CYC = 130,
  parameter int S3_CYC = 70
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrDone,
  input  logic                      ctrlUpd,
  input  logic [$clog2(NUM_CH)-1:0] wrChan,
  input  logic [DATA_W-1:0]         wrX1,
  input  logic [DATA_W-1:0]         wrGain,
  input  logic [DATA_W-1:0]         wrOffset,
  output logic                      stage1Busy,
  output logic                      overrun,
  output logic                      x2Valid,
  output logic [$clog2(NUM_CH)-1:0] x2Chan,
  output logic [DATA_W-1:0]         x2Data,
  output logic [NUM_CH*DATA_W-1:0]  x2Flat
);

  calStrobes_t strb;
  logic        startReq;

  assign startReq = wrDone | ctrlUpd;

  calCtrl #(.S1_CYC(S1_CYC), .S2_CYC(S2_CYC), .S3_CYC(S3_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .strb(strb),
    .stage1Busy(stage1Busy), .overrun(overrun)
  );

  calDatapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inChan(wrChan), .inX1(wrX1),
    .inGain(wrGain), .inOffset(wrOffset), .x2Valid(x2Valid),
    .x2Chan(x2Chan), .x2Data(x2Data), .x2Flat(x2Flat)
  );

endmodule

// File: tb/dacCalPipeline_bench.sv
module dacCalPipeline_bench;

  localparam int S1 = 130, S2 = 130, S3 = 70;
  localparam int LAT = S1 + S2 + S3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrDone = 1'b0, ctrlUpd = 1'b0;
  logic [1:0]  wrChan = '0;
  logic [15:0] wrX1 = '0, wrGain = '0, wrOffset = '0;
  logic        stage1Busy, overrun, x2Valid;
  logic [1:0]  x2Chan;
  logic [15:0] x2Data;
  logic [63:0] x2Flat;

  int checks = 0, errors = 0, cycleCnt = 0;
  int nV, ovSeen;
  int vObs [2];
  int vChan [2];
  int vData [2];
  int expBank [4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  dacCalPipeline u_dacCalPipeline (
    .clk(clk), .rstN(rstN), .wrDone(wrDone), .ctrlUpd(ctrlUpd),
    .wrChan(wrChan), .wrX1(wrX1), .wrGain(wrGain), .wrOffset(wrOffset),
    .stage1Busy(stage1Busy), .overrun(overrun), .x2Valid(x2Valid),
    .x2Chan(x2Chan), .x2Data(x2Data), .x2Flat(x2Flat)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: act %0d cycles exp completion", cycleCnt);
      summary();
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  function automatic int model(input int x1, input int m, input int c);
    longint p = longint'(x1) * longint'(m + 1);
    longint v = (p >>> 16) + c - 32768;
    if (v < 0) v = 0;
    if (v > 65535) v = 65535;
    return int'(v);
  endfunction

  function automatic int slot(input int ch);
    return int'(x2Flat[ch*16 +: 16]);
  endfunction

  // call at a negedge; returns at the first observation negedge after the sampling edge
  task automatic issue(input int ch, input int x1, input int m, input int c, input bit useCtrl);
    wrChan = 2'(ch); wrX1 = 16'(x1); wrGain = 16'(m); wrOffset = 16'(c);
    if (useCtrl) ctrlUpd = 1'b1; else wrDone = 1'b1;
    @(negedge clk);
    wrDone = 1'b0; ctrlUpd = 1'b0;
  endtask

  task automatic collect(input int obs0, input int span);
    nV = 0; ovSeen = 0;
    for (int k = 0; k < span; k++) begin
      if (x2Valid) begin
        if (nV < 2) begin
          vObs[nV] = obs0 + k; vChan[nV] = int'(x2Chan); vData[nV] = int'(x2Data);
        end
        nV++;
      end
      if (overrun) ovSeen++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 busy", stage1Busy, 0);
    check("R9 overrun", overrun, 0);
    check("R9 valid", x2Valid, 0);
    check("R9 bank", x2Flat, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testSingle(input string req, input int ch, input int x1,
                            input int m, input int c, input bit useCtrl);
    int e = model(x1, m, c);
    int other = (ch + 1) % 4;
    issue(ch, x1, m, c, useCtrl);
    collect(1, LAT + 5);
    check({req, " R1 latency"}, vObs[0], LAT + 1);
    check({req, " R4 pulses"}, nV, 1);
    check({req, " R2 data"}, vData[0], e);
    check({req, " R3 chan"}, vChan[0], ch);
    expBank[ch] = e;
    check({req, " R3 slot"}, slot(ch), e);
    check({req, " R3 other slot"}, slot(other), expBank[other]);
  endtask

  task automatic testBusy();
    issue(0, 100, 200, 300, 1'b0);
    check("R5 busy early", stage1Busy, 1);
    repeat (S1 - 2) @(negedge clk);
    check("R5 busy last-but-one", stage1Busy, 1);
    @(negedge clk);
    check("R5 busy released", stage1Busy, 0);
    collect(S1, LAT + 5);
    expBank[0] = model(100, 200, 300);
  endtask

  task automatic testBackToBack();
    int eA = model(40000, 50000, 33000);
    int eB = model(1234, 65535, 40000);
    issue(0, 40000, 50000, 33000, 1'b0);
    repeat (S1 - 1) @(negedge clk);
    check("R6 busy low at handoff", stage1Busy, 0);
    issue(1, 1234, 65535, 40000, 1'b0);
    collect(S1 + 1, LAT + 10);
    check("R6 overrun", ovSeen, 0);
    check("R6 count", nV, 2);
    check("R6 first time", vObs[0], LAT + 1);
    check("R6 first chan", vChan[0], 0);
    check("R6 first data", vData[0], eA);
    check("R6 second time", vObs[1], LAT + 1 + S1);
    check("R6 second chan", vChan[1], 1);
    check("R6 second data", vData[1], eB);
    expBank[0] = eA; expBank[1] = eB;
  endtask

  task automatic testOverrun();
    int eA = model(20000, 30000, 36000);
    issue(3, 20000, 30000, 36000, 1'b0);
    repeat (8) @(negedge clk);
    issue(2, 5, 5, 5, 1'b0);
    check("R7 overrun pulse", overrun, 1);
    collect(10, LAT + S1 + 10);
    check("R7 overrun width", ovSeen, 1);
    check("R7 one result", nV, 1);
    check("R7 survivor chan", vChan[0], 3);
    check("R7 survivor data", vData[0], eA);
    check("R7 dropped slot", slot(2), expBank[2]);
    expBank[3] = eA;
  endtask

  initial begin
    testReset();
    testSingle("unity", 1, 32768, 65535, 32768, 1'b0);
    testSingle("clampHigh", 2, 65535, 65535, 65535, 1'b0);
    testSingle("clampLow", 3, 0, 1000, 0, 1'b0);
    testSingle("halfGain", 0, 16384, 32767, 32768, 1'b0);
    testSingle("R8 ctrl", 1, 50000, 40000, 30000, 1'b1);
    testBusy();
    testBackToBack();
    testOverrun();
    summary();
  end

endmodule